// File: doc/BRIEF.md
# Interrupt Vector Fetch and Reset Start

This block decides where a processor's program flow continues after a reset or an accepted interrupt. While reset is held it presents a fixed start location: segment FFFFh with offset 0000h, which is physical address FFFF0h. When reset is released it pulses its load strobe once so the core loads that location into its code segment and instruction pointer.

When an interrupt request arrives with an 8-bit type, the block reads that type's four-byte pointer from the low-memory table. The table occupies 000h to 3FFh, and each entry starts at the type times four. The block reads the entry one byte at a time through a simple read port that waits on a ready signal. It then assembles a 16-bit offset and a 16-bit segment, presents them, and pulses the load strobe. A request that arrives while a fetch is running is held in a one-entry slot and served when the fetch finishes.

Top module: `ivec_fetch`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `new_seg` is FFFFh, `new_off` is 0000h, `load` is 0 and `mem_rd` is 0.
- R2: On the first clock edge after `rst` falls, `load` rises for one clock while `new_seg`=FFFFh and `new_off`=0000h, which points at physical address FFFF0h.
- R3: A fetch for type T reads the entry whose base byte address is T*4, so every read address lies in 000h to 3FFh.
- R4: The four bytes of an entry are read in ascending order: base, base+1, base+2, base+3.
- R5: The entry bytes map as follows: byte 0 is the offset low byte and byte 1 the offset high byte; byte 2 is the segment low byte and byte 3 the segment high byte.
- R6: `load` is high for exactly one clock, on the edge after the fourth byte is captured. `new_seg` and `new_off` change only on an edge that raises `load`.
- R7: An interrupt request that arrives while a fetch is in progress is held, and it is fetched after the current fetch completes, in arrival order.
- R8: Reset during a fetch abandons it. After reset is released, only the start-location strobe appears and the abandoned fetch does not resume.
- R9: A read is complete only on an edge where `mem_rd` and `mem_ready` are both high. Until then, `mem_rd` stays high and `mem_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_valid | input | 1 | Interrupt accepted; `irq_type` is valid |
| irq_type | input | 8 | Interrupt type, 0 to 255 |
| mem_addr | output | 20 | Byte read address |
| mem_rd | output | 1 | Read request |
| mem_data | input | 8 | Read data, sampled with `mem_ready` |
| mem_ready | input | 1 | Read data valid this cycle |
| new_seg | output | 16 | Code segment to load |
| new_off | output | 16 | Instruction pointer to load |
| load | output | 1 | One-clock strobe: load `new_seg`/`new_off` |

## Verification
The assertions assume that `mem_ready` is only considered while `mem_rd` is high. They also assume that `mem_data` is valid on the edge where both are high. The bench memory model raises ready only during a read, after a chosen number of wait cycles, and computes its data from the address. Interrupt requests are driven as one-cycle pulses, at most one while a fetch is busy, so the one-entry hold slot never sees a second pending request.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_READ = 1'b1} fetch_st_t;

  // Table entry size in bytes: a 16-bit offset followed by a 16-bit segment
  localparam int ENTRY_BYTES = 4;
  localparam int IDX_W       = $clog2(ENTRY_BYTES);
endpackage

// File: rtl/ivec_hold.sv
module ivec_hold #(
  parameter int TYPE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_valid,
  input  logic [TYPE_W-1:0] irq_type,
  input  logic              take,
  output logic              held_valid,
  output logic [TYPE_W-1:0] held_type
);
  // One-entry slot: a request waits here until the sequencer is idle
  always_ff @(posedge clk) begin
    if (rst) begin
      held_valid <= 1'b0;
      held_type  <= '0;
    end else if (take) begin
      held_valid <= irq_valid;
      held_type  <= irq_type;
    end else if (!held_valid && irq_valid) begin
      held_valid <= 1'b1;
      held_type  <= irq_type;
    end
  end

  // R7: a pending request is kept until the sequencer takes it
  a_r7_hold_kept: assert property (@(posedge clk) disable iff (rst)
    (held_valid && !take) |=> (held_valid && $stable(held_type)));
endmodule

// File: rtl/ivec_seq.sv
module ivec_seq
  import ivec_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int TYPE_W = 8,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                held_valid,
  input  logic [TYPE_W-1:0]   held_type,
  output logic                take,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_rd,
  input  logic [BYTE_W-1:0]   mem_data,
  input  logic                mem_ready,
  output logic                done,
  output logic [2*BYTE_W-1:0] ptr_seg,
  output logic [2*BYTE_W-1:0] ptr_off
);
  localparam int WORD_W   = 2 * BYTE_W;
  localparam int TABLE_SZ = (1 << TYPE_W) * ENTRY_BYTES;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRY_BYTES - 1);

  fetch_st_t          st;
  logic [IDX_W-1:0]   idx;
  logic [BYTE_W-1:0]  buf_q [ENTRY_BYTES-1];
  logic [ADDR_W-1:0]  base;
  logic               beat;

  // entry base = type * 4
  assign base = ADDR_W'({held_type, {IDX_W{1'b0}}});
  assign take = (st == ST_IDLE) && held_valid;
  assign beat = (st == ST_READ) && mem_ready;
  assign done = beat && (idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      idx      <= '0;
      mem_rd   <= 1'b0;
      mem_addr <= '0;
    end else begin
      case (st)
        ST_IDLE: if (held_valid) begin
          st       <= ST_READ;
          idx      <= '0;
          mem_rd   <= 1'b1;
          mem_addr <= base;
        end
        ST_READ: if (mem_ready) begin
          if (idx == LAST) begin
            st     <= ST_IDLE;
            mem_rd <= 1'b0;
          end else begin
            idx      <= idx + IDX_W'(1);
            mem_addr <= mem_addr + ADDR_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // capture the first three bytes; the last one is used straight from the port
  for (genvar g = 0; g < ENTRY_BYTES - 1; g++) begin : g_cap
    always_ff @(posedge clk) begin
      if (beat && idx == IDX_W'(g)) buf_q[g] <= mem_data;
    end
  end

  logic [ENTRY_BYTES*BYTE_W-1:0] entry;
  assign entry   = {mem_data, buf_q[2], buf_q[1], buf_q[0]};
  assign ptr_off = entry[WORD_W-1:0];
  assign ptr_seg = entry[2*WORD_W-1:WORD_W];

  // R9: a read in wait state keeps its request and address
  a_r9_wait_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));
  // R4: reads step up one byte at a time within an entry
  a_r4_ascending: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && mem_ready && idx != LAST) |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));
  // R3: reads stay inside the pointer table
  a_r3_in_table: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (mem_addr < ADDR_W'(TABLE_SZ)));
endmodule

// File: rtl/ivec_out.sv
module ivec_out #(
  parameter int          WORD_W    = 16,
  parameter logic [15:0] RESET_SEG = 16'hFFFF,
  parameter logic [15:0] RESET_OFF = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [WORD_W-1:0] ptr_seg,
  input  logic [WORD_W-1:0] ptr_off,
  output logic [WORD_W-1:0] new_seg,
  output logic [WORD_W-1:0] new_off,
  output logic              load
);
  logic boot_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      new_seg   <= WORD_W'(RESET_SEG);
      new_off   <= WORD_W'(RESET_OFF);
      load      <= 1'b0;
      boot_pend <= 1'b1;
    end else if (boot_pend) begin
      load      <= 1'b1;
      boot_pend <= 1'b0;
    end else if (done) begin
      new_seg <= ptr_seg;
      new_off <= ptr_off;
      load    <= 1'b1;
    end else begin
      load <= 1'b0;
    end
  end

  // R6: strobe lasts one clock
  a_r6_one_clock: assert property (@(posedge clk) disable iff (rst)
    load |=> !load);
  // R6: the pointer changes only together with the strobe
  a_r6_seg_with_load: assert property (@(posedge clk) disable iff (rst)
    !$stable(new_seg) |-> load);
  a_r6_off_with_load: assert property (@(posedge clk) disable iff (rst)
    !$stable(new_off) |-> load);
endmodule

// File: rtl/ivec_fetch.sv
module ivec_fetch #(
  parameter int          ADDR_W    = 20,
  parameter int          TYPE_W    = 8,
  parameter int          BYTE_W    = 8,
  parameter logic [15:0] RESET_SEG = 16'hFFFF,
  parameter logic [15:0] RESET_OFF = 16'h0000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                irq_valid,
  input  logic [TYPE_W-1:0]   irq_type,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_rd,
  input  logic [BYTE_W-1:0]   mem_data,
  input  logic                mem_ready,
  output logic [2*BYTE_W-1:0] new_seg,
  output logic [2*BYTE_W-1:0] new_off,
  output logic                load
);
  localparam int WORD_W = 2 * BYTE_W;

  logic              take, held_valid, done;
  logic [TYPE_W-1:0] held_type;
  logic [WORD_W-1:0] ptr_seg, ptr_off;

  ivec_hold #(.TYPE_W(TYPE_W)) u_hold (
    .clk(clk), .rst(rst), .irq_valid(irq_valid), .irq_type(irq_type),
    .take(take), .held_valid(held_valid), .held_type(held_type)
  );

  ivec_seq #(.ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst(rst), .held_valid(held_valid), .held_type(held_type),
    .take(take), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_data(mem_data),
    .mem_ready(mem_ready), .done(done), .ptr_seg(ptr_seg), .ptr_off(ptr_off)
  );

  ivec_out #(.WORD_W(WORD_W), .RESET_SEG(RESET_SEG), .RESET_OFF(RESET_OFF)) u_out (
    .clk(clk), .rst(rst), .done(done), .ptr_seg(ptr_seg), .ptr_off(ptr_off),
    .new_seg(new_seg), .new_off(new_off), .load(load)
  );
endmodule

// File: tb/test_ivec_fetch.sv
module test_ivec_fetch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_valid = 1'b0;
  logic [7:0]  irq_type = '0;
  logic [19:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_data;
  logic        mem_ready;
  logic [15:0] new_seg, new_off;
  logic        load;

  int n_tests = 0;
  int n_fail  = 0;
  int wait_n  = 0;
  int wcnt    = 0;
  int loads   = 0;
  int cyc     = 0;
  logic [19:0] rec [16];
  int rec_n = 0;

  always #2.5 clk = ~clk;

  ivec_fetch i_ivec_fetch (
    .clk(clk), .rst(rst), .irq_valid(irq_valid), .irq_type(irq_type),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_data(mem_data),
    .mem_ready(mem_ready), .new_seg(new_seg), .new_off(new_off), .load(load)
  );

  function automatic logic [7:0] mb(input logic [19:0] a);
    return (a[7:0] * 8'd37) ^ {6'b0, a[9:8]} ^ 8'h5A;
  endfunction

  assign mem_data  = mb(mem_addr);
  assign mem_ready = mem_rd && (wcnt >= wait_n);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (load) loads <= loads + 1;
    if (mem_rd && !mem_ready) wcnt <= wcnt + 1; else wcnt <= 0;
    if (mem_rd && mem_ready) begin
      rec[rec_n % 16] <= mem_addr;
      rec_n <= rec_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fire(input logic [7:0] t);
    @(negedge clk); irq_valid = 1'b1; irq_type = t;
    @(negedge clk); irq_valid = 1'b0;
  endtask

  // waits (at negedges) for a load strobe; checks pointer of type t
  task automatic expect_load(input logic [7:0] t, input int start);
    bit seen = 0;
    logic [19:0] b = {10'b0, t, 2'b00};
    logic [15:0] es = {mb(b + 3), mb(b + 2)};
    logic [15:0] eo = {mb(b + 1), mb(b)};
    for (int k = 0; k < 200 && !seen; k++) begin
      if (load) seen = 1; else @(negedge clk);
    end
    chk(seen, "R6 strobe seen", {31'b0, seen}, 1);
    chk(new_seg == es, "R5 segment", new_seg, es);
    chk(new_off == eo, "R5 offset", new_off, eo);
    for (int k = 0; k < 4; k++)   // R3 base = type*4, R4 ascending, R9 under waits
      chk(rec[(start + k) % 16] == b + 20'(k), "R4 read order", rec[(start + k) % 16], b + 20'(k));
    @(negedge clk);
    chk(!load, "R6 one clock", {31'b0, load}, 0);
  endtask

  localparam logic [15:0] VEC [8] = '{
    16'h0000, 16'h0102, 16'hFF01, 16'h8003,
    16'h7F00, 16'h4001, 16'hFE02, 16'h0300
  };

  initial begin
    int st;
    int l0;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(new_seg == 16'hFFFF && new_off == 16'h0000, "R1 reset pointer", {new_seg, new_off}, 32'hFFFF0000);
    chk(!load && !mem_rd, "R1 idle in reset", {30'b0, load, mem_rd}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(load && new_seg == 16'hFFFF && new_off == 16'h0000, "R2 start strobe", {load, 15'b0, new_seg}, 32'h8000FFFF);
    @(negedge clk);
    chk(!load, "R2 strobe one clock", {31'b0, load}, 0);

    foreach (VEC[i]) begin
      wait_n = int'(VEC[i][7:0]);
      st = rec_n;
      fire(VEC[i][15:8]);
      expect_load(VEC[i][15:8], st);
      repeat (2) @(negedge clk);
    end

    // R7 request during busy fetch is held and served next
    wait_n = 1;
    st = rec_n;
    fire(8'h12);
    @(negedge clk);
    fire(8'h34);
    expect_load(8'h12, st);
    expect_load(8'h34, st + 4);

    // R8 reset mid-fetch abandons it
    wait_n = 3;
    fire(8'h55);
    repeat (2) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(new_seg == 16'hFFFF && new_off == 16'h0000 && !mem_rd, "R8 reset mid-fetch",
        {new_seg, new_off}, 32'hFFFF0000);
    rst = 1'b0;
    l0 = loads;
    @(negedge clk);
    chk(load, "R8 start strobe after abort", {31'b0, load}, 1);
    repeat (30) @(negedge clk);
    chk(loads == l0 + 1 && new_seg == 16'hFFFF, "R8 no resumed fetch", loads - l0, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule